// File: doc/BRIEF.md
# Microcode Sequencer with Handshake Dwell

This block is the control unit of a statically scheduled sequential machine. A program counter addresses a synchronous microcode ROM. The ROM is written as a case statement over the address and holds a fixed example program. The ROM is read through three registers in series: a PC latch, the ROM read register and a routing register. Every step therefore yields one pre-decoded control word, which carries operator issue strobes, a write opcode and per-operator commit windows. Each word appears a fixed three cycles after its PC.

The PC stops at only two places. At address 0 it waits for an input handshake and pulses a one-cycle load. At the last address it raises out_valid and waits for out_ready. The end-of-transaction install strobe fires only when both out_valid and out_ready are high. At every other address the PC follows a per-address terminator table. The default is to step by one. One address branches on a 1-bit condition, and one address jumps backward to form a loop.

While the PC dwells, the same word keeps arriving at the routing stage. A transacting flag that travels with each word masks those repeats to NOP. The same flag also gates operator error flags through each word's commit window. A latch keeps the PC of the most recent error and clears on every accept.

Top module: `ucode_seq`

## Requirements
- R1: Reset, asynchronous and active-low, has these effects:
  - It puts the PC at 0, with out_valid_o, transacting_o, err_seen_o and err_pc_o all low.
  - It fills the fetch registers with the word at address 0.
  - It gives exec_pc_o = 0.
- R2: in_ready_o is high exactly while the PC is 0. While the PC is 0 and in_valid_i is low, the PC stays 0 and load_o stays low. While the PC is 0 and in_valid_i is high, load_o is high for that cycle and the PC moves to 1.
- R3: At addresses 1, 2, 4, 6, 7 and 8 the PC advances by exactly one each clock.
- R4: Address 3 is a branch. It goes to 6 when cond_i is 1 and to 4 when cond_i is 0. Address 5 jumps back to 3.
- R5: out_valid_o is high exactly while the PC is 9. The PC holds at 9 until out_ready_i is high, then returns to 0. install_o equals out_valid_o AND out_ready_i.
- R6: exec_pc_o equals the PC value from three clock edges earlier (fetch lag 3).
- R7: The ROM image is given as (issue[1:0], wop[2:0], commit[1:0]) per address:
  - 0: (01,1,00)
  - 1: (10,2,00)
  - 2: NOP
  - 3: (01,3,01)
  - 4: (00,4,10)
  - 5: (11,5,00)
  - 6: NOP
  - 7: (10,6,01)
  - 8: (00,7,11)
  - 9: (01,1,00)
  - All other addresses: NOP, which is all zero.
- R8: A step is live in three cases: at PC 0 in the accept cycle, at PCs 1 to 8, and at PC 9 on its first cycle only. transacting_o is the liveness of the step whose word is being routed. While transacting_o is low, issue_o and wop_o are 0.
- R9: err_o is the OR over operators k of the term op_err_i[k] AND commit[k] of the routed word AND transacting_o.
- R10: The error latch works as follows:
  - When err_o is high, err_pc_o takes exec_pc_o and err_seen_o is set on the next edge.
  - An accept clears both on the next edge. An accept takes priority over a same-cycle error.
- R11: The cycle in which out_valid_o first rises comes 7 + 3·n cycles after the accept cycle. Here n is the number of times the branch at address 3 took the not-taken path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Input transaction offered |
| in_ready_o | output | 1 | Sequencer waiting at address 0 |
| load_o | output | 1 | One-cycle input load strobe on accept |
| cond_i | input | 1 | Branch condition register value |
| out_valid_o | output | 1 | Result presented at last address |
| out_ready_i | input | 1 | Result taken |
| install_o | output | 1 | State install strobe |
| op_err_i | input | 2 | Per-operator raw error flags |
| pc_o | output | 4 | Current program counter |
| exec_pc_o | output | 4 | Address of the routed word |
| transacting_o | output | 1 | Routed word belongs to a live step |
| issue_o | output | 2 | Gated operator issue strobes |
| wop_o | output | 3 | Gated write opcode |
| err_o | output | 1 | Commit-window-gated error |
| err_pc_o | output | 4 | Address of the latest error |
| err_seen_o | output | 1 | An error has occurred since the last accept |

## Verification
The handshake outputs (in_ready_o, load_o, out_valid_o, install_o) come from the PC register and the same-cycle inputs, so they are due in the cycle the inputs are applied. The PC is due one edge later. The routed word, exec_pc_o and transacting_o are due three edges after the step that fetched them. err_o follows op_err_i in the same cycle, and the error latch updates one edge after err_o. The bench applies inputs just after each falling edge and samples 1 ns later. It keeps a three-deep history of expected PC and liveness, so every control output is compared with the step three cycles back. Latency per transaction is counted from the accept cycle to the first out_valid_o.

// File: rtl/useq_pkg.sv
`timescale 1ns/1ps
package useq_pkg;
  localparam int PC_W  = 4;
  localparam int N_OPS = 2;
  localparam int WOP_W = 3;
  localparam logic [PC_W-1:0] LAST_PC = PC_W'(9);

  typedef struct packed {
    logic [N_OPS-1:0] issue;
    logic [WOP_W-1:0] wop;
    logic [N_OPS-1:0] commit;
  } uword_t;

  localparam uword_t NOP_WORD = '0;
  localparam uword_t WORD0    = '{issue: N_OPS'(1), wop: WOP_W'(1), commit: '0};

  typedef enum logic [1:0] {T_STEP, T_JUMP, T_BRANCH} term_kind_e;

  typedef struct packed {
    term_kind_e      kind;
    logic [PC_W-1:0] tgt_t;
    logic [PC_W-1:0] tgt_f;
  } term_t;

  // per-address terminator table
  function automatic term_t term_of(input logic [PC_W-1:0] pc);
    term_t t;
    t.kind  = T_STEP;
    t.tgt_t = pc + PC_W'(1);
    t.tgt_f = pc + PC_W'(1);
    case (pc)
      PC_W'(3): begin t.kind = T_BRANCH; t.tgt_t = PC_W'(6); t.tgt_f = PC_W'(4); end
      PC_W'(5): begin t.kind = T_JUMP;   t.tgt_t = PC_W'(3); t.tgt_f = PC_W'(3); end
      default: ;
    endcase
    return t;
  endfunction
endpackage

// File: rtl/useq_pc_ctl.sv
`timescale 1ns/1ps
module useq_pc_ctl
  import useq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  input  logic            out_ready_i,
  input  logic            cond_i,
  output logic [PC_W-1:0] pc_o,
  output logic            in_ready_o,
  output logic            load_o,
  output logic            out_valid_o,
  output logic            install_o,
  output logic            live_o
);
  logic [PC_W-1:0] pc_q, pc_d;
  logic            dwell_q;
  logic            at_first, at_last;
  term_t           term;

  assign term     = term_of(pc_q);
  assign at_first = (pc_q == '0);
  assign at_last  = (pc_q == LAST_PC);

  always_comb begin
    pc_d = pc_q;
    if (at_first)      pc_d = in_valid_i ? PC_W'(1) : '0;
    else if (at_last)  pc_d = out_ready_i ? '0 : LAST_PC;
    else begin
      unique case (term.kind)
        T_BRANCH: pc_d = cond_i ? term.tgt_t : term.tgt_f;
        T_JUMP:   pc_d = term.tgt_t;
        default:  pc_d = pc_q + PC_W'(1);
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= '0;
      dwell_q <= 1'b0;
    end else begin
      pc_q    <= pc_d;
      dwell_q <= at_last && !out_ready_i;
    end
  end

  // a dwell re-fetch at the last address is not live
  assign live_o      = at_first ? in_valid_i : (at_last ? !dwell_q : 1'b1);
  assign pc_o        = pc_q;
  assign in_ready_o  = at_first;
  assign load_o      = at_first && in_valid_i;
  assign out_valid_o = at_last;
  assign install_o   = at_last && out_ready_i;

  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_first && !in_valid_i) |=> (pc_q == '0));
  // R3
  step_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!at_first && !at_last && term.kind == T_STEP) |=> (pc_q == $past(pc_q) + PC_W'(1)));
  // R4
  back_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_q == PC_W'(5)) |=> (pc_q == PC_W'(3)));
  // R4
  branch_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_q == PC_W'(3) && cond_i) |=> (pc_q == PC_W'(6)));
  // R5
  out_dwell_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && !live_o));
endmodule

// File: rtl/useq_fetch.sv
`timescale 1ns/1ps
module useq_fetch
  import useq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] pc_i,
  input  logic            live_i,
  output uword_t          word_o,
  output logic [PC_W-1:0] pc_o,
  output logic            live_o
);
  logic [PC_W-1:0] pc_lat_q, pc_rd_q;
  logic            live_lat_q, live_rd_q;
  uword_t          rom_q;

  // PC latch stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_lat_q   <= '0;
      live_lat_q <= 1'b0;
      pc_rd_q    <= '0;
      live_rd_q  <= 1'b0;
    end else begin
      pc_lat_q   <= pc_i;
      live_lat_q <= live_i;
      pc_rd_q    <= pc_lat_q;
      live_rd_q  <= live_lat_q;
    end
  end

  // ROM read register: dedicated clocked case-over-address block
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rom_q <= WORD0;
    else begin
      case (pc_lat_q)
        PC_W'(0): rom_q <= WORD0;
        PC_W'(1): rom_q <= '{issue: 2'b10, wop: 3'd2, commit: 2'b00};
        PC_W'(3): rom_q <= '{issue: 2'b01, wop: 3'd3, commit: 2'b01};
        PC_W'(4): rom_q <= '{issue: 2'b00, wop: 3'd4, commit: 2'b10};
        PC_W'(5): rom_q <= '{issue: 2'b11, wop: 3'd5, commit: 2'b00};
        PC_W'(7): rom_q <= '{issue: 2'b10, wop: 3'd6, commit: 2'b01};
        PC_W'(8): rom_q <= '{issue: 2'b00, wop: 3'd7, commit: 2'b11};
        PC_W'(9): rom_q <= '{issue: 2'b01, wop: 3'd1, commit: 2'b00};
        default:  rom_q <= NOP_WORD;
      endcase
    end
  end

  assign word_o = rom_q;
  assign pc_o   = pc_rd_q;
  assign live_o = live_rd_q;
endmodule

// File: rtl/useq_route.sv
`timescale 1ns/1ps
module useq_route
  import useq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  uword_t           word_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic             live_i,
  input  logic [N_OPS-1:0] op_err_i,
  output logic [PC_W-1:0]  exec_pc_o,
  output logic             transacting_o,
  output logic [N_OPS-1:0] issue_o,
  output logic [WOP_W-1:0] wop_o,
  output logic             err_o,
  output logic [PC_W-1:0]  err_pc_o,
  output logic             err_seen_o
);
  uword_t           route_q;
  logic [PC_W-1:0]  pc_q, err_pc_q;
  logic             live_q, err_seen_q;
  logic [N_OPS-1:0] err_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      route_q <= WORD0;
      pc_q    <= '0;
      live_q  <= 1'b0;
    end else begin
      route_q <= word_i;
      pc_q    <= pc_i;
      live_q  <= live_i;
    end
  end

  for (genvar k = 0; k < N_OPS; k++) begin : g_op
    assign issue_o[k] = route_q.issue[k] & live_q;
    assign err_hit[k] = op_err_i[k] & route_q.commit[k] & live_q;
  end

  assign wop_o         = live_q ? route_q.wop : '0;
  assign err_o         = |err_hit;
  assign exec_pc_o     = pc_q;
  assign transacting_o = live_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_pc_q   <= '0;
      err_seen_q <= 1'b0;
    end else if (accept_i) begin
      err_pc_q   <= '0;
      err_seen_q <= 1'b0;
    end else if (err_o) begin
      err_pc_q   <= pc_q;
      err_seen_q <= 1'b1;
    end
  end

  assign err_pc_o   = err_pc_q;
  assign err_seen_o = err_seen_q;

  // R10
  accept_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |=> (!err_seen_o && err_pc_o == '0));
  // R10
  err_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !accept_i) |=> (err_seen_o && err_pc_o == $past(exec_pc_o)));
endmodule

// File: rtl/ucode_seq.sv
`timescale 1ns/1ps
module ucode_seq
  import useq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  output logic             load_o,
  input  logic             cond_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic             install_o,
  input  logic [N_OPS-1:0] op_err_i,
  output logic [PC_W-1:0]  pc_o,
  output logic [PC_W-1:0]  exec_pc_o,
  output logic             transacting_o,
  output logic [N_OPS-1:0] issue_o,
  output logic [WOP_W-1:0] wop_o,
  output logic             err_o,
  output logic [PC_W-1:0]  err_pc_o,
  output logic             err_seen_o
);
  logic            live_s0, live_s2;
  logic [PC_W-1:0] pc_s2;
  uword_t          word_s2;

  useq_pc_ctl u_pc (
    .clk_i, .rst_ni, .in_valid_i, .out_ready_i, .cond_i,
    .pc_o, .in_ready_o, .load_o, .out_valid_o, .install_o,
    .live_o(live_s0)
  );

  useq_fetch u_fetch (
    .clk_i, .rst_ni,
    .pc_i(pc_o), .live_i(live_s0),
    .word_o(word_s2), .pc_o(pc_s2), .live_o(live_s2)
  );

  useq_route u_route (
    .clk_i, .rst_ni,
    .accept_i(load_o), .word_i(word_s2), .pc_i(pc_s2), .live_i(live_s2),
    .op_err_i, .exec_pc_o, .transacting_o, .issue_o, .wop_o,
    .err_o, .err_pc_o, .err_seen_o
  );

  // R6
  fetch_lag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_pc_o == $past(pc_o, 3));
  // R8
  dwell_inert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_ready_o && !in_valid_i) |=> ##2 !transacting_o);
endmodule

// File: tb/tb_ucode_seq.sv
`timescale 1ns/1ps
module tb_ucode_seq;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       in_valid_i = 1'b0, cond_i = 1'b0, out_ready_i = 1'b0;
  logic [1:0] op_err_i = '0;
  logic       in_ready_o, load_o, out_valid_o, install_o, transacting_o, err_o, err_seen_o;
  logic [3:0] pc_o, exec_pc_o, err_pc_o;
  logic [1:0] issue_o;
  logic [2:0] wop_o;

  int n_chk = 0, n_err = 0;

  // model state
  logic [3:0] e_pc, e_errpc;
  logic       e_atl, e_errseen;
  logic [3:0] h_pc [3];
  logic       h_lv [3];

  // {loop passes, in delay, out delay, error mask}
  localparam int VEC [6][4] = '{
    '{0, 0, 0, 0}, '{1, 2, 0, 1}, '{3, 0, 2, 2},
    '{2, 1, 1, 3}, '{0, 3, 4, 1}, '{4, 0, 0, 0}
  };

  ucode_seq dut (.clk_i(clk), .*);

  always #2.5 clk = ~clk;

  function automatic logic [6:0] wexp(input logic [3:0] a);
    case (a)
      4'd0: return {2'b01, 3'd1, 2'b00};
      4'd1: return {2'b10, 3'd2, 2'b00};
      4'd3: return {2'b01, 3'd3, 2'b01};
      4'd4: return {2'b00, 3'd4, 2'b10};
      4'd5: return {2'b11, 3'd5, 2'b00};
      4'd7: return {2'b10, 3'd6, 2'b01};
      4'd8: return {2'b00, 3'd7, 2'b11};
      4'd9: return {2'b01, 3'd1, 2'b00};
      default: return 7'd0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    e_pc = '0; e_atl = 1'b0; e_errpc = '0; e_errseen = 1'b0;
    for (int i = 0; i < 3; i++) begin h_pc[i] = '0; h_lv[i] = 1'b0; end
  endtask

  task automatic tick(input logic iv, input logic orr, input logic c, input logic [1:0] oe);
    logic [6:0] w;
    logic [3:0] np;
    logic       lv, ee, acc;
    in_valid_i = iv; out_ready_i = orr; cond_i = c; op_err_i = oe;
    #1;
    w   = wexp(h_pc[2]);
    acc = (e_pc == 4'd0) && iv;
    ee  = h_lv[2] && |(oe & w[1:0]);
    chk(in_ready_o == (e_pc == 4'd0), "R2", "in_ready", in_ready_o, e_pc == 4'd0);
    chk(load_o == acc, "R2", "load", load_o, acc);
    chk(pc_o == e_pc, (e_pc == 4'd4 || e_pc == 4'd6 || (e_pc == 4'd3 && h_pc[0] == 4'd5)) ? "R4" : "R3",
        "pc", pc_o, e_pc);
    chk(out_valid_o == (e_pc == 4'd9), "R5", "out_valid", out_valid_o, e_pc == 4'd9);
    chk(install_o == ((e_pc == 4'd9) && orr), "R5", "install", install_o, (e_pc == 4'd9) && orr);
    chk(exec_pc_o == h_pc[2], "R6", "exec_pc", exec_pc_o, h_pc[2]);
    chk(transacting_o == h_lv[2], "R8", "transacting", transacting_o, h_lv[2]);
    chk(issue_o == (h_lv[2] ? w[6:5] : 2'b0), h_lv[2] ? "R7" : "R8", "issue", issue_o, h_lv[2] ? w[6:5] : 0);
    chk(wop_o == (h_lv[2] ? w[4:2] : 3'b0), h_lv[2] ? "R7" : "R8", "wop", wop_o, h_lv[2] ? w[4:2] : 0);
    chk(err_o == ee, "R9", "err", err_o, ee);
    chk(err_pc_o == e_errpc, "R10", "err_pc", err_pc_o, e_errpc);
    chk(err_seen_o == e_errseen, "R10", "err_seen", err_seen_o, e_errseen);
    // next-state model
    lv = (e_pc == 4'd0) ? iv : ((e_pc == 4'd9) ? !e_atl : 1'b1);
    case (e_pc)
      4'd0: np = iv ? 4'd1 : 4'd0;
      4'd9: np = orr ? 4'd0 : 4'd9;
      4'd3: np = c ? 4'd6 : 4'd4;
      4'd5: np = 4'd3;
      default: np = e_pc + 4'd1;
    endcase
    if (acc) begin e_errpc = '0; e_errseen = 1'b0; end
    else if (ee) begin e_errpc = h_pc[2]; e_errseen = 1'b1; end
    e_atl = (e_pc == 4'd9) && !orr;
    h_pc[2] = h_pc[1]; h_lv[2] = h_lv[1];
    h_pc[1] = h_pc[0]; h_lv[1] = h_lv[0];
    h_pc[0] = e_pc;    h_lv[0] = lv;
    e_pc = np;
  endtask

  task automatic check_reset_state();
    chk(pc_o == 4'd0, "R1", "reset pc", pc_o, 0);
    chk(out_valid_o == 1'b0, "R1", "reset out_valid", out_valid_o, 0);
    chk(transacting_o == 1'b0, "R1", "reset transacting", transacting_o, 0);
    chk(exec_pc_o == 4'd0, "R1", "reset exec_pc", exec_pc_o, 0);
    chk(err_seen_o == 1'b0 && err_pc_o == 4'd0, "R1", "reset err latch", err_seen_o, 0);
    chk(issue_o == 2'b0 && wop_o == 3'b0, "R1", "reset masked word", {issue_o, wop_o}, 0);
  endtask

  task automatic run_txn(input int it, input int ind, input int outd, input logic [1:0] em);
    int  visits, waitc, lastc, lat, guard;
    bit  acc, done;
    logic iv, orr, c;
    visits = 0; waitc = 0; lastc = 0; lat = 0; guard = 0; acc = 0; done = 0;
    while (!done && guard < 400) begin
      @(negedge clk);
      guard++;
      iv = 1'b0; orr = 1'b0; c = 1'b0;
      if (acc) lat++;
      if (pc_o == 4'd0 && !acc) begin
        iv = (waitc >= ind);
        waitc++;
        if (iv) begin acc = 1; lat = 0; end
      end
      if (pc_o == 4'd3) begin c = (visits >= it); visits++; end
      if (pc_o == 4'd9 && acc) begin
        if (lastc == 0)
          chk(lat == 7 + 3 * it, "R11", "latency", lat, 7 + 3 * it);
        orr = (lastc >= outd);
        lastc++;
        if (orr) done = 1;
      end
      tick(iv, orr, c, em);
    end
    if (!done) chk(1'b0, "R11", "transaction did not complete", guard, 0);
  endtask

  initial begin
    #(200000 * 5);
    chk(1'b0, "R11", "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    check_reset_state();
    rst_ni = 1'b1;
    // idle: no in_valid, PC must stay at 0
    for (int i = 0; i < 5; i++) begin @(negedge clk); tick(1'b0, 1'b0, 1'b0, 2'b11); end
    for (int v = 0; v < 6; v++) run_txn(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3][1:0]);
    for (int i = 0; i < 4; i++) begin @(negedge clk); tick(1'b0, 1'b1, 1'b0, 2'b00); end
    // asynchronous reset in the middle of a transaction
    @(negedge clk); tick(1'b1, 1'b0, 1'b0, 2'b00);
    for (int i = 0; i < 4; i++) begin @(negedge clk); tick(1'b0, 1'b0, 1'b0, 2'b11); end
    #1 rst_ni = 1'b0;
    in_valid_i = 1'b0; op_err_i = '0;
    repeat (4) @(negedge clk);
    check_reset_state();
    model_reset();
    rst_ni = 1'b1;
    run_txn(1, 0, 1, 2'b10);
    for (int i = 0; i < 4; i++) begin @(negedge clk); tick(1'b0, 1'b0, 1'b0, 2'b00); end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule